// File: doc/BRIEF.md
# Serial Command Front End with Frame-Length Guard

This block is the slave side of a four-wire serial link in clock mode 0. A controller lowers chip-select, sends a 24-bit command least significant bit first, and raises chip-select. The block samples data on the rising edge of the serial clock and updates its serial output on the falling edge. The first bit of each command chooses one of two control registers. The same bit chooses which of two status words is returned during that frame.

The block counts the serial clocks in each frame. If the count is not exactly 24, nothing is written and no strobe fires. A valid command can clear the status sources through a one-cycle strobe. It can also put the block into standby, which wipes both control registers. After reset the block is in standby.

As soon as chip-select drops, the serial output shows a summary bit. This lets a controller poll the summary without clocking. All pins are brought into a faster system clock through synchronisers, and edges are detected there.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A valid frame stores received bit k (k = 0 is the first bit on the line) at bit k of the chosen control register.
- R2: Received bit 0 equal to 0 chooses control register 0, and equal to 1 chooses control register 1. The register that is not chosen keeps its value.
- R3: A frame with any clock count other than 24 (including 0 and more than 24) changes neither register, nor standby, nor any strobe.
- R4: Each valid write with received bit 23 set raises exactly one of the two write strobe bits, for one system clock. Bit 0 of the strobe marks register 0 and bit 1 marks register 1.
- R5: A valid frame with received bit 22 set pulses the clear strobe for one system clock. Invalid frames never pulse it.
- R6: A valid frame with received bit 23 clear sets standby, zeroes both control registers and raises no write strobe. A valid frame with bit 23 set clears standby.
- R7: After reset, standby is 1, both control registers are zero and the output enable is 0.
- R8: The output enable follows chip-select low. The serial data output is 0 whenever the enable is 0.
- R9: Before any clock in a frame, the serial output shows the summary bit. The summary bit is 1 exactly when all 44 bits of the two status inputs are 0.
- R10: Over a 24-clock frame, the output presents a 24-bit word. Its bit 0 is the summary bit. Its bits 1 to 22 are status input bits 0 to 21 of the status word chosen by received bit 0. Its bit 23 is always 1. Each later bit appears after a falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csn_i | input | 1 | Chip-select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, idle low |
| di_i | input | 1 | Serial data in, least significant bit first |
| stat0_i | input | 22 | Status word 0, bits 1 to 22 of the returned word |
| stat1_i | input | 22 | Status word 1, bits 1 to 22 of the returned word |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for the serial data pin |
| ctrl0_o | output | 24 | Control register 0 |
| ctrl1_o | output | 24 | Control register 1 |
| wr_stb_o | output | 2 | One-cycle write strobe, one bit per register |
| clr_stb_o | output | 1 | One-cycle status-clear strobe |
| standby_o | output | 1 | Standby state |

## Verification
The properties assume that chip-select, the serial clock and data change no faster than the synchronisers can follow. They also assume that a chip-select edge and a serial clock edge never land in the same synchronised cycle, and that reset is held for at least one clock. The stimulus holds every serial level for at least four system clocks. It changes data only while the serial clock is low, well clear of either edge, and keeps chip-select steady around every clock edge. With those assumptions, the properties state when control registers may change, that strobes are single-cycle, and that data stays quiet while the output is disabled.

// File: rtl/spi_cmd_pkg.sv
// Shared constants and types for the serial command front end.
// Assumes a fixed frame length chosen once per build.
package spi_cmd_pkg;
    localparam int unsigned FRAME_BITS = 24;

    // Raw serial pins as seen at the block edge.
    typedef struct packed {
        logic csn;
        logic sclk;
        logic di;
    } spi_pins_t;

    // Synchronised events presented to the frame and status logic.
    typedef struct packed {
        logic csn_fall;
        logic csn_rise;
        logic sclk_rise;
        logic sclk_fall;
        logic di;
        logic csn_low;
    } spi_evt_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings the three serial pins into the system clock and detects edges.
// Assumes STAGES >= 2 and pins slower than the system clock.
// Clock edges are reported only while chip-select is low.
module spi_pin_sync
    import spi_cmd_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  spi_pins_t pins_i,
    output spi_evt_t  evt_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] csn_r, sclk_r, di_r;
    logic              csn_d, sclk_d;
    logic              csn_now, sclk_now;

    // Synchroniser chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_r  <= '1;
            sclk_r <= '0;
            di_r   <= '0;
            csn_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            csn_r  <= {csn_r[STAGES-2:0], pins_i.csn};
            sclk_r <= {sclk_r[STAGES-2:0], pins_i.sclk};
            di_r   <= {di_r[STAGES-2:0], pins_i.di};
            csn_d  <= csn_r[LAST];
            sclk_d <= sclk_r[LAST];
        end
    end

    assign csn_now  = csn_r[LAST];
    assign sclk_now = sclk_r[LAST];

    // Edge decode from the synchronised levels.
    always_comb begin
        evt_o.csn_fall  = csn_d & ~csn_now;
        evt_o.csn_rise  = ~csn_d & csn_now;
        evt_o.sclk_rise = ~sclk_d & sclk_now & ~csn_now;
        evt_o.sclk_fall = sclk_d & ~sclk_now & ~csn_now;
        evt_o.di        = di_r[LAST];
        evt_o.csn_low   = ~csn_now;
    end
endmodule

// File: rtl/spi_frame_rx.sv
// Shifts in the serial word LSB first and counts clocks in each frame.
// The counter saturates one above W so an overlong frame cannot wrap to W.
// At the end of a frame, done_o pulses for one cycle and ok_o reports the count check.
module spi_frame_rx
    import spi_cmd_pkg::*;
#(
    parameter int unsigned W = FRAME_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  spi_evt_t     evt_i,
    output logic [W-1:0] word_o,
    output logic         done_o,
    output logic         ok_o
);
    localparam int unsigned CW = $clog2(W + 2);
    localparam logic [CW-1:0] SAT  = CW'(W + 1);
    localparam logic [CW-1:0] GOOD = CW'(W);

    logic [CW-1:0] cnt_q;

    // Shift register, saturating bit counter and end-of-frame report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '0;
            cnt_q  <= '0;
            done_o <= 1'b0;
            ok_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (evt_i.csn_fall) begin
                cnt_q <= '0;
            end else if (evt_i.sclk_rise) begin
                word_o <= {evt_i.di, word_o[W-1:1]};
                if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
            end
            if (evt_i.csn_rise) begin
                done_o <= 1'b1;
                ok_o   <= (cnt_q == GOOD);
            end
        end
    end
endmodule

// File: rtl/spi_status_tx.sv
// Drives the serial output: the summary bit from chip-select fall, then the
// chosen status word loaded on the first rising clock and shifted on falls.
// The summary bit is 1 when no status input bit is set.
module spi_status_tx
    import spi_cmd_pkg::*;
#(
    parameter int unsigned W = FRAME_BITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  spi_evt_t     evt_i,
    input  logic [W-3:0] stat0_i,
    input  logic [W-3:0] stat1_i,
    output logic         do_o,
    output logic         oe_o
);
    logic [W-1:0] tx_q;
    logic         loaded_q;
    logic         oe_q;
    logic         summary;
    logic [W-1:0] word0, word1;

    // Summary bit and the two candidate output words.
    always_comb begin
        summary = ~(|{stat0_i, stat1_i});
        word0   = {1'b1, stat0_i, summary};
        word1   = {1'b1, stat1_i, summary};
    end

    // Output shifter, first-clock load flag and enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q     <= '0;
            loaded_q <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            oe_q <= evt_i.csn_low;
            if (evt_i.csn_fall) begin
                tx_q     <= {{(W-1){1'b0}}, summary};
                loaded_q <= 1'b0;
            end else if (evt_i.sclk_rise && !loaded_q) begin
                tx_q     <= evt_i.di ? word1 : word0;
                loaded_q <= 1'b1;
            end else if (evt_i.sclk_fall && loaded_q) begin
                tx_q <= {1'b0, tx_q[W-1:1]};
            end
        end
    end

    assign oe_o = oe_q;
    assign do_o = oe_q & tx_q[0];
endmodule

// File: rtl/spi_cmd_frontend.sv
// Top of the serial command front end. It joins the pin synchroniser, the
// frame receiver and the status transmitter, and owns the two control
// registers, standby state and strobes. Bit 0 of the word selects the
// register, bit W-2 requests a status clear, and bit W-1 clear means standby.
module spi_cmd_frontend
    import spi_cmd_pkg::*;
#(
    parameter int unsigned W           = FRAME_BITS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         csn_i,
    input  logic         sclk_i,
    input  logic         di_i,
    input  logic [W-3:0] stat0_i,
    input  logic [W-3:0] stat1_i,
    output logic         do_o,
    output logic         do_oe_o,
    output logic [W-1:0] ctrl0_o,
    output logic [W-1:0] ctrl1_o,
    output logic [1:0]   wr_stb_o,
    output logic         clr_stb_o,
    output logic         standby_o
);
    localparam int unsigned SEL_BIT = 0;
    localparam int unsigned CLR_BIT = W - 2;
    localparam int unsigned RUN_BIT = W - 1;
    localparam int unsigned NREG    = 2;

    spi_pins_t    pins;
    spi_evt_t     evt;
    logic [W-1:0] word;
    logic         done, ok, accept, run;
    logic [W-1:0] ctrl_q [NREG];

    assign pins = '{csn: csn_i, sclk: sclk_i, di: di_i};

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins),
        .evt_o  (evt)
    );

    spi_frame_rx #(.W(W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .word_o (word),
        .done_o (done),
        .ok_o   (ok)
    );

    spi_status_tx #(.W(W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt),
        .stat0_i (stat0_i),
        .stat1_i (stat1_i),
        .do_o    (do_o),
        .oe_o    (do_oe_o)
    );

    assign accept = done & ok;
    assign run    = word[RUN_BIT];

    // One control register per select value; standby wipes both.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[g] <= '0;
            end else if (accept && !run) begin
                ctrl_q[g] <= '0;
            end else if (accept && (word[SEL_BIT] == 1'(g))) begin
                ctrl_q[g] <= word;
            end
        end
    end

    // Standby state and the single-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            standby_o <= 1'b1;
            wr_stb_o  <= '0;
            clr_stb_o <= 1'b0;
        end else begin
            wr_stb_o  <= '0;
            clr_stb_o <= 1'b0;
            if (accept) begin
                clr_stb_o <= word[CLR_BIT];
                standby_o <= ~run;
                if (run) wr_stb_o <= word[SEL_BIT] ? 2'b10 : 2'b01;
            end
        end
    end

    assign ctrl0_o = ctrl_q[0];
    assign ctrl1_o = ctrl_q[1];
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
// Property checker for the serial command front end, attached by bind.
// Assumes reset is held for at least one clock before release.
module spi_cmd_frontend_chk #(
    parameter int unsigned W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic         do_o,
    input logic         do_oe_o,
    input logic [W-1:0] ctrl0_o,
    input logic [W-1:0] ctrl1_o,
    input logic [1:0]   wr_stb_o,
    input logic         clr_stb_o,
    input logic         standby_o
);
    AST_WR_ONE_REG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb_o)); // R4
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_o != 2'b00) |=> (wr_stb_o == 2'b00)); // R4
    AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb_o |=> !clr_stb_o); // R5
    AST_DO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !do_oe_o |-> !do_o); // R8
    AST_CTRL0_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl0_o) |-> (wr_stb_o[0] || $rose(standby_o))); // R3
    AST_CTRL1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl1_o) |-> (wr_stb_o[1] || $rose(standby_o))); // R3
    AST_STBY_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        standby_o |-> (wr_stb_o == 2'b00)); // R6
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .do_o      (do_o),
    .do_oe_o   (do_oe_o),
    .ctrl0_o   (ctrl0_o),
    .ctrl1_o   (ctrl1_o),
    .wr_stb_o  (wr_stb_o),
    .clr_stb_o (clr_stb_o),
    .standby_o (standby_o)
);

// File: tb/test_spi_cmd_frontend.sv
// Bench: sweeps frame lengths, both selects, standby and clear commands,
// and a walking-one over both status inputs, against an arithmetic model.
module test_spi_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csn = 1'b1, sclk = 1'b0, di = 1'b0;
    logic [21:0] s0 = '0, s1 = '0;
    logic        do_w, oe_w, clr_w, stby_w;
    logic [23:0] c0_w, c1_w;
    logic [1:0]  wr_w;

    int total = 0, bad = 0, cyc = 0;
    int wr0_n = 0, wr1_n = 0, clr_n = 0;
    int e_wr0 = 0, e_wr1 = 0, e_clr = 0;
    logic [23:0] m_c0 = '0, m_c1 = '0;
    logic        m_stby = 1'b1;

    always #4 clk = ~clk;

    spi_cmd_frontend i_spi_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .csn_i(csn), .sclk_i(sclk), .di_i(di),
        .stat0_i(s0), .stat1_i(s1), .do_o(do_w), .do_oe_o(oe_w),
        .ctrl0_o(c0_w), .ctrl1_o(c1_w), .wr_stb_o(wr_w),
        .clr_stb_o(clr_w), .standby_o(stby_w)
    );

    // Strobe pulse counters: one increment per high cycle.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && wr_w[0]) wr0_n <= wr0_n + 1;
        if (rst_n && wr_w[1]) wr1_n <= wr1_n + 1;
        if (rst_n && clr_w)   clr_n <= clr_n + 1;
        if (cyc > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp<=190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        check({tag, " ctrl0"}, 32'(c0_w), 32'(m_c0));
        check({tag, " ctrl1"}, 32'(c1_w), 32'(m_c1));
        check({tag, " standby"}, 32'(stby_w), 32'(m_stby));
        check({tag, " wr0 pulses R4"}, 32'(wr0_n), 32'(e_wr0));
        check({tag, " wr1 pulses R4"}, 32'(wr1_n), 32'(e_wr1));
        check({tag, " clr pulses R5"}, 32'(clr_n), 32'(e_clr));
        check("R8 idle enable/data", {30'd0, oe_w, do_w}, 32'd0);
    endtask

    // Sends n clocks of w (zeros beyond bit 23), then updates the model and checks.
    task automatic send(input logic [23:0] w, input int n, input logic chk_do, input string tag);
        logic [23:0] got, expw, sw;
        logic        summ;
        got  = '0;
        summ = ~(|{s0, s1});
        sw   = w[0] ? {1'b1, s1, summ} : {1'b1, s0, summ};
        expw = sw;
        wait_cyc(1);
        csn = 1'b0;
        wait_cyc(8);
        check("R8 enable in frame", 32'(oe_w), 32'd1);
        got[0] = do_w;
        check("R9 summary before clock", 32'(do_w), 32'(summ));
        for (int i = 0; i < n; i++) begin
            di = (i < 24) ? w[i] : 1'b0;
            wait_cyc(4);
            sclk = 1'b1;
            wait_cyc(8);
            sclk = 1'b0;
            wait_cyc(6);
            if (i < 23) got[i+1] = do_w;
        end
        wait_cyc(4);
        csn = 1'b1;
        di  = 1'b0;
        wait_cyc(12);
        if (n == 24) begin
            if (w[22]) e_clr = e_clr + 1;
            if (!w[23]) begin
                m_stby = 1'b1; m_c0 = '0; m_c1 = '0;
            end else begin
                m_stby = 1'b0;
                if (w[0]) begin m_c1 = w; e_wr1 = e_wr1 + 1; end
                else      begin m_c0 = w; e_wr0 = e_wr0 + 1; end
            end
        end
        if (chk_do) check("R10 output word", 32'(got), 32'(expw));
        check_state(tag);
    endtask

    initial begin
        wait_cyc(4);
        check("R7 standby after reset", 32'(stby_w), 32'd1);
        check("R7 ctrl0 after reset", 32'(c0_w), 32'd0);
        check("R7 ctrl1 after reset", 32'(c1_w), 32'd0);
        check("R7 enable after reset", 32'(oe_w), 32'd0);
        rst_n = 1'b1;
        wait_cyc(4);
        check_state("R7 idle");

        // R1 R2: patterns to each register
        send(24'hA5C3_5A, 24, 1'b1, "R1 reg0 pattern");
        send(24'h8123_47, 24, 1'b1, "R2 reg1 pattern");
        send(24'hFF00_FE, 24, 1'b1, "R1 reg0 second");
        send(24'h9F0F_F1, 24, 1'b1, "R2 reg1 second");

        // R3: length sweep; only 24 clocks may write
        for (int n = 0; n <= 30; n++) begin
            logic [23:0] w;
            w = {1'b1, 1'b0, 6'(n), 15'h2D96 ^ 15'(n * 97), 1'(n)};
            send(w, n, 1'b0, (n == 24) ? "R1 sweep valid" : "R3 sweep bad length");
        end

        // R5: clear request, valid then invalid
        send(24'hC000_10, 24, 1'b1, "R5 clear valid");
        send(24'hC000_11, 23, 1'b0, "R5 R3 clear short");
        send(24'hC000_11, 25, 1'b0, "R5 R3 clear long");

        // R6: standby wipes both, then wake
        send(24'h4ABC_DE, 24, 1'b1, "R6 standby with clear");
        send(24'h0000_01, 24, 1'b1, "R6 standby again");
        send(24'h8000_03, 24, 1'b1, "R6 wake reg1");

        // R9 R10: walking one over both status inputs, plus all ones
        for (int sel = 0; sel < 2; sel++) begin
            for (int k = 0; k < 22; k++) begin
                s0 = (sel == 0) ? 22'(1) << k : '0;
                s1 = (sel == 1) ? 22'(1) << k : '0;
                send({1'b1, 1'b0, 21'(k), 1'(sel)}, 24, 1'b1, "R10 walk");
            end
        end
        s0 = '1; s1 = '0;
        send(24'h8000_01, 24, 1'b1, "R9 other reg loaded");
        s0 = '0; s1 = '0;
        send(24'h8000_00, 24, 1'b1, "R9 all quiet");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule